// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a clocked request port and an external asynchronous static RAM of 64K words by 16 bits. A client presents a word address, a read/write flag, write data and a two-bit lane mask under a valid/ready handshake. The controller turns each accepted request into registered, glitch-free pin activity: a 16-bit address, active-low chip, output, write and per-byte strobes, and a split data bus with its own drive enable. Read results come back on a data port with a one-cycle valid pulse.

All pin timing comes from nanosecond parameters. Each one is rounded up to whole clock cycles against the clock period. At the default 5 ns clock this gives a two-cycle write strobe, a two-cycle read access and one idle turnaround cycle. The mask picks which byte lanes take part. Bit 0 selects data bits 7..0 through the lower strobe, and bit 1 selects bits 15..8 through the upper strobe. A lane with its bit clear is not written, and it reads back as zero. Before a write that follows a read, the controller keeps the data pins quiet long enough for the memory to release them.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Reset, and the cycle that follows it, hold every memory strobe (chip, output, write, lower, upper) high, the drive enable low, rsp_valid low and req_ready high.
- R2: req_ready is high only while no access is in progress. A request is taken on a clock edge where req_valid and req_ready are both high, and req_ready is low in the cycle after that edge.
- R3: For a write that does not follow a read, the cycle after acceptance shows chip and write strobes low, drive enable high, the request address on mem_addr and the write data on mem_dq_out. The lower strobe is low exactly when mask bit 0 is 1, and the upper strobe is low exactly when mask bit 1 is 1. The write strobe stays low for WP cycles (2 at defaults), then all strobes rise on the same edge.
- R4: A write changes only the byte lanes whose mask bit is 1. A write with mask 0 leaves the word unchanged, and this shows when the word is read back.
- R5: For a read, the cycle after acceptance shows chip, output and the selected lane strobes low and write high. The output strobe stays low for ACC cycles (2 at defaults). Data is sampled on the edge that ends the access, and rsp_valid is high for exactly one cycle starting at that edge, ACC cycles after acceptance.
- R6: In rsp_rdata, the bits of a lane whose mask bit was 0 are zero, and a read with mask 0 returns 0. The bits of an enabled lane equal the last value written to that byte.
- R7: The data drive enable is high only in cycles where the write strobe is low and the output strobe is high.
- R8: A write accepted after a read first spends TURN idle cycles (1 at defaults) with all strobes high. As a result, the drive enable rises only after the output strobe has been high for at least two full cycles. The controller and the memory never drive the data pins in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_addr | input | 16 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 = bits 7..0, bit 1 = bits 15..8 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_in | input | 16 | Data from the memory |
| mem_dq_oe | output | 1 | Controller drives the data pins |

## Verification
Full-word writes and reads at the lowest and highest addresses show that address and data reach the pins unchanged. Lower-only, upper-only and empty-mask writes over a known word, read back under every mask, tell a lane merge apart from a whole-word write or a missing zero fill. Back-to-back read-then-write pairs separate a correct turnaround from a missing one, because the memory model keeps driving for one cycle after its output strobe rises. The memory model returns wrong data until the access time has elapsed, so any early sample shows up in the read data. A long random mix of masks and directions over a small set of addresses produces many lane overlaps and direction changes.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TURN  = 2'd1,
        ST_WRITE = 2'd2,
        ST_READ  = 2'd3
    } sramc_state_e;

    // Whole clock cycles needed to cover t_ps, never less than one.
    function automatic int cycles_for(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sramc_lanes.sv
module sramc_lanes #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic [LANES-1:0]  strobe_mask,
    output logic [LANES-1:0]  strobe_n,
    input  logic [LANES-1:0]  data_mask,
    input  logic [DATA_W-1:0] rd_raw,
    output logic [DATA_W-1:0] rd_merged
);

    localparam int LANE_W = DATA_W / LANES;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign strobe_n[g] = ~strobe_mask[g];
        assign rd_merged[g*LANE_W +: LANE_W] =
            data_mask[g] ? rd_raw[g*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int CLK_PS   = 5000,
    parameter int T_ACC_PS = 10000,
    parameter int T_WP_PS  = 8000,
    parameter int T_AW_PS  = 8000,
    parameter int T_DW_PS  = 5000,
    parameter int T_HZ_PS  = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    import sramc_pkg::*;

    localparam int LANES    = 2;
    localparam int ACC_CYC  = cycles_for(T_ACC_PS, CLK_PS);
    localparam int WP_CYC   = max3(cycles_for(T_WP_PS, CLK_PS),
                                   cycles_for(T_AW_PS, CLK_PS),
                                   cycles_for(T_DW_PS, CLK_PS));
    localparam int TURN_CYC = cycles_for(T_HZ_PS, CLK_PS);
    localparam int MAX_CYC  = max3(ACC_CYC, WP_CYC, TURN_CYC);
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    typedef struct packed {
        sramc_state_e      st;
        logic              last_rd;
        logic [LANES-1:0]  mask;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic [LANES-1:0]  lane_n;
        logic              dq_oe;
        logic              rsp_v;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st:      ST_IDLE,
        last_rd: 1'b0,
        mask:    '0,
        addr:    '0,
        wdata:   '0,
        ce_n:    1'b1,
        oe_n:    1'b1,
        we_n:    1'b1,
        lane_n:  '1,
        dq_oe:   1'b0,
        rsp_v:   1'b0,
        rdata:   '0
    };

    regs_t r_d, r_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic [LANES-1:0] lane_sel;
    logic [LANES-1:0] lane_strobe_n;
    logic [DATA_W-1:0] rd_merged;

    // In idle the strobes follow the incoming mask; otherwise the held one.
    assign lane_sel = (r_q.st == ST_IDLE) ? req_mask : r_q.mask;

    sramc_lanes #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_lanes (
        .strobe_mask (lane_sel),
        .strobe_n    (lane_strobe_n),
        .data_mask   (r_q.mask),
        .rd_raw      (mem_dq_in),
        .rd_merged   (rd_merged)
    );

    sramc_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        r_d      = r_q;
        r_d.rsp_v = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.mask  = req_mask;
                    if (req_write) begin
                        r_d.last_rd = 1'b0;
                        if (r_q.last_rd) begin
                            r_d.st   = ST_TURN;
                            tmr_load = 1'b1;
                            tmr_val  = CNT_W'(TURN_CYC - 1);
                        end else begin
                            r_d.st     = ST_WRITE;
                            r_d.ce_n   = 1'b0;
                            r_d.we_n   = 1'b0;
                            r_d.lane_n = lane_strobe_n;
                            r_d.dq_oe  = 1'b1;
                            tmr_load   = 1'b1;
                            tmr_val    = CNT_W'(WP_CYC - 1);
                        end
                    end else begin
                        r_d.last_rd = 1'b1;
                        r_d.st      = ST_READ;
                        r_d.ce_n    = 1'b0;
                        r_d.oe_n    = 1'b0;
                        r_d.lane_n  = lane_strobe_n;
                        tmr_load    = 1'b1;
                        tmr_val     = CNT_W'(ACC_CYC - 1);
                    end
                end
            end
            ST_TURN: begin
                if (tmr_expired) begin
                    r_d.st     = ST_WRITE;
                    r_d.ce_n   = 1'b0;
                    r_d.we_n   = 1'b0;
                    r_d.lane_n = lane_strobe_n;
                    r_d.dq_oe  = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(WP_CYC - 1);
                end
            end
            ST_WRITE: begin
                if (tmr_expired) begin
                    r_d.st     = ST_IDLE;
                    r_d.ce_n   = 1'b1;
                    r_d.we_n   = 1'b1;
                    r_d.lane_n = '1;
                    r_d.dq_oe  = 1'b0;
                end
            end
            ST_READ: begin
                if (tmr_expired) begin
                    r_d.st     = ST_IDLE;
                    r_d.ce_n   = 1'b1;
                    r_d.oe_n   = 1'b1;
                    r_d.lane_n = '1;
                    r_d.rsp_v  = 1'b1;
                    r_d.rdata  = rd_merged;
                end
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign rsp_valid  = r_q.rsp_v;
    assign rsp_rdata  = r_q.rdata;
    assign mem_addr   = r_q.addr;
    assign mem_ce_n   = r_q.ce_n;
    assign mem_oe_n   = r_q.oe_n;
    assign mem_we_n   = r_q.we_n;
    assign mem_lb_n   = r_q.lane_n[0];
    assign mem_ub_n   = r_q.lane_n[1];
    assign mem_dq_out = r_q.wdata;
    assign mem_dq_oe  = r_q.dq_oe;

    // Run length of the write strobe, for the pulse width property.
    logic [CNT_W:0] we_low_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_q <= '0;
        end else if (!mem_we_n) begin
            if (we_low_q != '1) we_low_q <= we_low_q + 1'b1;
        end else begin
            we_low_q <= '0;
        end
    end

    assert_ready_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_dq_oe));

    assert_write_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    assert_write_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_q >= (CNT_W+1)'(WP_CYC)));

    assert_rsp_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_drive_in_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n));

    assert_turn_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> ($past(mem_oe_n) && $past(mem_oe_n, 2)));

endmodule

// File: tb/sim_sram_lane_ctrl.sv
`timescale 1ns/1ps
module sim_sram_lane_ctrl;

    localparam int WP   = 2;
    localparam int ACC  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [15:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in;
    logic        mem_dq_oe;

    always #2.5 clk = ~clk;

    sram_lane_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- behavioural memory model ----------------
    bit [15:0] model_mem [int];
    int  acc_cnt = 0;
    bit  hold = 1'b0;
    logic rd_act, model_drv;

    function automatic logic [15:0] mget(input logic [15:0] a);
        return model_mem.exists(int'(a)) ? model_mem[int'(a)] : 16'h0000;
    endfunction

    assign rd_act = !mem_ce_n && !mem_oe_n && mem_we_n && (!mem_lb_n || !mem_ub_n);
    assign model_drv = rd_act || hold;

    always @(posedge clk) begin
        logic [15:0] w;
        if (!rst_n) begin
            acc_cnt <= 0;
            hold <= 1'b0;
        end else begin
            acc_cnt <= rd_act ? acc_cnt + 1 : 0;
            hold <= rd_act;
            if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
                w = mget(mem_addr);
                if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
                if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
                model_mem[int'(mem_addr)] = w;
            end
        end
    end

    always @* begin
        logic [15:0] v;
        v = mget(mem_addr);
        if (acc_cnt < ACC - 1) v = ~v ^ 16'h5A5A;
        if (mem_lb_n) v[7:0] = 8'h00;
        if (mem_ub_n) v[15:8] = 8'h00;
        mem_dq_in = model_drv ? v : 16'h0000;
    end

    // ---------------- scoreboard ----------------
    bit [15:0] exp_mem [int];
    logic [15:0] q_data [$];
    int          q_cyc  [$];
    bit last_rd = 1'b0;

    function automatic logic [15:0] eget(input logic [15:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 16'h0000;
    endfunction

    task automatic op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                      input logic [1:0] m);
        logic [15:0] w;
        req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R2 ready low after accept", 32'(req_ready), 32'd0);
        if (wr) begin
            w = eget(a);
            if (m[0]) w[7:0]  = d[7:0];
            if (m[1]) w[15:8] = d[15:8];
            exp_mem[int'(a)] = w;
            if (last_rd) begin
                check(mem_we_n && !mem_dq_oe && mem_ce_n, "R8 turnaround idle cycle",
                      {29'd0, mem_we_n, mem_dq_oe, mem_ce_n}, 32'h5);
                @(negedge clk);
            end
            check(!mem_we_n && !mem_ce_n && mem_dq_oe && mem_oe_n &&
                  mem_lb_n == !m[0] && mem_ub_n == !m[1],
                  "R3 write strobes",
                  {26'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe},
                  {26'd0, 1'b0, 1'b1, 1'b0, !m[0], !m[1], 1'b1});
            check(mem_addr == a && mem_dq_out == d, "R3 write address and data",
                  {mem_addr, mem_dq_out}, {a, d});
            last_rd = 1'b0;
        end else begin
            w = eget(a);
            if (!m[0]) w[7:0]  = 8'h00;
            if (!m[1]) w[15:8] = 8'h00;
            q_data.push_back(w);
            q_cyc.push_back(cyc + ACC);
            check(!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe &&
                  mem_lb_n == !m[0] && mem_ub_n == !m[1] && mem_addr == a,
                  "R5 read strobes",
                  {10'd0, mem_addr, mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe},
                  {10'd0, a, 1'b0, 1'b0, 1'b1, !m[0], !m[1], 1'b0});
            last_rd = 1'b1;
        end
    endtask

    // ---------------- monitors ----------------
    int  we_run = 0, oe_run = 0, since_oe = 100;
    bit  prev_rsp = 1'b0, prev_oe = 1'b0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_valid) begin
                check(!prev_rsp, "R5 rsp_valid single cycle", 32'(prev_rsp), 32'd0);
                if (q_data.size() == 0) begin
                    check(1'b0, "R5 unexpected response", 32'(rsp_rdata), 32'd0);
                end else begin
                    logic [15:0] ed;
                    int ec;
                    ed = q_data.pop_front();
                    ec = q_cyc.pop_front();
                    check(rsp_rdata == ed, "R4 R6 read data lane merge", 32'(rsp_rdata), 32'(ed));
                    check(cyc == ec, "R5 response latency", 32'(cyc), 32'(ec));
                end
            end
            prev_rsp = rsp_valid;

            if (!mem_we_n) we_run++;
            else if (we_run > 0) begin
                check(we_run == WP, "R3 write strobe width", 32'(we_run), 32'(WP));
                we_run = 0;
            end
            if (!mem_oe_n) oe_run++;
            else if (oe_run > 0) begin
                check(oe_run == ACC, "R5 read strobe width", 32'(oe_run), 32'(ACC));
                oe_run = 0;
            end

            if (!mem_oe_n) since_oe = 0;
            else if (since_oe < 100) since_oe++;
            if (mem_dq_oe && !prev_oe)
                check(since_oe >= 3, "R8 gap before drive", 32'(since_oe), 32'd3);
            prev_oe = mem_dq_oe;

            if (mem_dq_oe && (mem_we_n || !mem_oe_n))
                check(1'b0, "R7 drive outside write", {30'd0, mem_we_n, mem_oe_n}, 32'h1);
            if (mem_dq_oe && model_drv)
                check(1'b0, "R8 bus contention", 32'd1, 32'd0);
        end
    end

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    task automatic idle_state_check(input string tag);
        check(mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n &&
              !mem_dq_oe && !rsp_valid && req_ready, tag,
              {25'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n,
               mem_dq_oe, rsp_valid, req_ready},
              32'h000000F9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        idle_state_check("R1 state during reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle_state_check("R1 state after reset");

        // full words at the address extremes
        op(1'b1, 16'h0000, 16'h1234, 2'b11);
        op(1'b1, 16'hFFFF, 16'hBEEF, 2'b11);
        op(1'b0, 16'h0000, 16'h0000, 2'b11);
        op(1'b0, 16'hFFFF, 16'h0000, 2'b11);

        // masked writes over a known word
        op(1'b1, 16'h0040, 16'hAABB, 2'b11);
        op(1'b1, 16'h0040, 16'h1122, 2'b01);
        op(1'b0, 16'h0040, 16'h0000, 2'b11);
        op(1'b1, 16'h0040, 16'h3344, 2'b10);
        op(1'b0, 16'h0040, 16'h0000, 2'b11);
        op(1'b1, 16'h0040, 16'h5566, 2'b00);
        op(1'b0, 16'h0040, 16'h0000, 2'b11);

        // read under each mask
        op(1'b0, 16'h0040, 16'h0000, 2'b01);
        op(1'b0, 16'h0040, 16'h0000, 2'b10);
        op(1'b0, 16'h0040, 16'h0000, 2'b00);

        // read then write back to back, then write then read
        op(1'b1, 16'h0041, 16'h7788, 2'b11);
        op(1'b0, 16'h0041, 16'h0000, 2'b11);

        for (int i = 0; i < 200; i++) begin
            logic [15:0] a;
            a = (i % 2 == 1) ? (16'hFFF8 | 16'($urandom % 8)) : 16'($urandom % 8);
            op(1'($urandom % 2), a, 16'($urandom), 2'($urandom % 4));
        end

        repeat (8) @(negedge clk);
        check(q_data.size() == 0, "R5 all reads answered", 32'(q_data.size()), 32'd0);
        idle_state_check("R1 idle after traffic");
        done = 1'b1;
        report();
    end

endmodule